// File: doc/BRIEF.md
# Repetition-Divided PWM Update Generator

This block is a 16-bit PWM time base. Its update events are thinned out by an 8-bit repetition downcounter. The main counter runs in one of two modes:

- Edge mode: it counts from zero up to the active auto-reload value, then wraps to zero.
- Center mode: it counts up to the auto-reload value, then back down to zero.

Every wrap, top turn or bottom turn is a counter event. The repetition downcounter holds for `REP` counter events and acts on the next one. On that event it emits a one-clock update pulse, reloads itself from the repetition register and copies the auto-reload preload into the active reload register. With interrupts enabled, the same update sets a sticky interrupt flag.

Software uses a four-word register port with combinational read-back:

| Address | Register | Fields |
|---|---|---|
| 0 | Control | bit 0 run, bit 1 center mode, bit 2 interrupt enable, bit 3 force-update strobe (reads 0) |
| 1 | Repetition value | bits 7:0; bits 15:8 read as 0 |
| 2 | Auto-reload preload | 16 bits |
| 3 | Status | bit 0 update flag |

Writing the control register with bit 3 set forces an update at once. Both the repetition value and the reload value are buffered: a new value only shapes the period that follows the next update.

Top module: `rep_update_gen`

## Requirements
- R1: The repetition register (address 1) resets to 0, stores bits 7:0 of a write, and always reads bits 15:8 as 0.
- R2: After reset, `cnt_o` is 0, `update_o` and `irq_o` are 0, the control register reads 0 and the auto-reload register (address 2) reads 16'hFFFF.
- R3: In edge mode (control bit 1 = 0) with active reload A ≥ 1 and repetition value R, consecutive update pulses are exactly (A+1)·(R+1) clocks apart.
- R4: In center mode (control bit 1 = 1) with A ≥ 1, consecutive update pulses are exactly A·(R+1) clocks apart, because both the top turn and the bottom turn count.
- R5: With R = 0, every counter event (wrap, top turn or bottom turn) yields an update pulse.
- R6: A write to the repetition register leaves the period in progress unchanged. The new value first governs the interval after the next update.
- R7: A write to the auto-reload register leaves the period in progress unchanged. The active reload takes the new value only at an update.
- R8: A control write with bit 3 set gives `update_o` = 1 and `cnt_o` = 0 in the following cycle, and reloads the repetition downcounter from the repetition register.
- R9: With control bit 2 = 1, an update sets the flag (`irq_o`, status bit 0). Writing status bit 0 = 1 leaves the flag set; writing it as 0 clears it.
- R10: With control bit 2 = 0, updates leave `irq_o` at 0.
- R11: Each update pulse is one clock wide when the update interval is longer than one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| cnt_o | output | 16 | Main counter value |
| update_o | output | 1 | Update event pulse |
| irq_o | output | 1 | Sticky update interrupt flag |

## Verification
The bench sweeps a table of mode, reload and repetition combinations and measures the spacing of settled update pulses against the closed-form interval:

- The edge and center entries that share a reload value tell the full-period count apart from the half-period count.
- The zero-repetition entries separate "every event" from an off-by-one in the downcounter.
- The repetition-255 entry exercises the full width of the downcounter.

Directed runs change the repetition and reload values just after a pulse. They then check that one more interval keeps the old length before the new one appears, which tells buffered loading apart from immediate loading. The remaining directed runs cover the forced update, the flag's set/hold/clear rules and reserved-bit read-back.

// File: rtl/rep_pkg.sv
package rep_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_REP  = 2'd1;
  localparam logic [ADDR_W-1:0] A_ARR  = 2'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

  localparam int unsigned B_EN     = 0;
  localparam int unsigned B_CENTER = 1;
  localparam int unsigned B_UIE    = 2;
  localparam int unsigned B_UG     = 3;

  typedef struct packed {
    logic uie;
    logic center;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/rep_regs.sv
module rep_regs
  import rep_pkg::*;
#(
  parameter int unsigned BUS_W   = 16,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned REP_W   = 8,
  parameter logic [CNT_W-1:0] ARR_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              upd_i,
  output logic [BUS_W-1:0]  rdata_o,
  output ctrl_t             ctrl_o,
  output logic              ug_o,
  output logic [REP_W-1:0]  rep_val_o,
  output logic [CNT_W-1:0]  arr_act_o,
  output logic              flag_o
);
  ctrl_t             ctrl_q;
  logic [REP_W-1:0]  rep_q;
  logic [CNT_W-1:0]  arr_pre_q, arr_act_q;
  logic              flag_q;

  assign ug_o = we_i && (addr_i == A_CTRL) && wdata_i[B_UG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      rep_q     <= '0;
      arr_pre_q <= ARR_RST;
    end else if (we_i) begin
      unique case (addr_i)
        A_CTRL: ctrl_q <= '{uie: wdata_i[B_UIE], center: wdata_i[B_CENTER], en: wdata_i[B_EN]};
        A_REP:  rep_q  <= wdata_i[REP_W-1:0];
        A_ARR:  arr_pre_q <= wdata_i[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  // active reload follows preload only on update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    arr_act_q <= ARR_RST;
    else if (upd_i) arr_act_q <= arr_pre_q;
  end

  // set wins over a clearing write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                        flag_q <= 1'b0;
    else if (upd_i && ctrl_q.uie)                       flag_q <= 1'b1;
    else if (we_i && addr_i == A_STAT && !wdata_i[0])   flag_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: begin
        rdata_o[B_EN]     = ctrl_q.en;
        rdata_o[B_CENTER] = ctrl_q.center;
        rdata_o[B_UIE]    = ctrl_q.uie;
      end
      A_REP:  rdata_o[REP_W-1:0] = rep_q;
      A_ARR:  rdata_o[CNT_W-1:0] = arr_pre_q;
      default: rdata_o[0] = flag_q;
    endcase
  end

  assign ctrl_o    = ctrl_q;
  assign rep_val_o = rep_q;
  assign arr_act_o = arr_act_q;
  assign flag_o    = flag_q;

  // R9
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && ctrl_q.uie |=> flag_q);
  // R7
  arr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(arr_act_q));
endmodule

// File: rtl/rep_time_base.sv
module rep_time_base #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             center_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] arr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ev_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             up_q;
  logic             at_top, at_bot;

  assign at_top = (cnt_q == arr_i);
  assign at_bot = (cnt_q == '0);
  assign ev_o   = en_i && (center_i ? (up_q ? at_top : at_bot) : at_top);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (clr_i) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (en_i) begin
      if (!center_i) begin
        up_q  <= 1'b1;
        cnt_q <= at_top ? '0 : cnt_q + 1'b1;
      end else if (up_q) begin
        if (at_top) begin
          cnt_q <= cnt_q - 1'b1;
          up_q  <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        if (at_bot) begin
          cnt_q <= cnt_q + 1'b1;
          up_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign cnt_o = cnt_q;

  // R3
  edge_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !center_i && !clr_i && at_top |=> cnt_q == '0);
  // R4
  center_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && center_i && !clr_i && up_q && at_top && arr_i != '0 |=> cnt_q == $past(arr_i) - 1'b1);
  // R8
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/rep_repeat.sv
module rep_repeat #(
  parameter int unsigned REP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ev_i,
  input  logic             ug_i,
  input  logic [REP_W-1:0] rep_val_i,
  output logic             upd_o
);
  logic [REP_W-1:0] rep_cnt_q;
  logic             zero;

  assign zero  = (rep_cnt_q == '0);
  assign upd_o = ug_i || (ev_i && zero);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rep_cnt_q <= '0;
    else if (upd_o) rep_cnt_q <= rep_val_i;
    else if (ev_i)  rep_cnt_q <= rep_cnt_q - 1'b1;
  end

  // R6
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> rep_cnt_q == $past(rep_val_i));
  // R3
  dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i && !ug_i && !zero |=> rep_cnt_q == $past(rep_cnt_q) - 1'b1);
  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ev_i && !ug_i |=> $stable(rep_cnt_q));
endmodule

// File: rtl/rep_update_gen.sv
module rep_update_gen
  import rep_pkg::*;
#(
  parameter int unsigned BUS_W = 16,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned REP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              update_o,
  output logic              irq_o
);
  ctrl_t            ctrl;
  logic             ug, upd, ev;
  logic [REP_W-1:0] rep_val;
  logic [CNT_W-1:0] arr_act;
  logic             upd_q;

  rep_regs #(.BUS_W(BUS_W), .CNT_W(CNT_W), .REP_W(REP_W)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .upd_i(upd), .rdata_o, .ctrl_o(ctrl), .ug_o(ug),
    .rep_val_o(rep_val), .arr_act_o(arr_act), .flag_o(irq_o)
  );

  rep_time_base #(.CNT_W(CNT_W)) u_tb (
    .clk_i, .rst_ni, .en_i(ctrl.en), .center_i(ctrl.center),
    .clr_i(ug), .arr_i(arr_act), .cnt_o, .ev_o(ev)
  );

  rep_repeat #(.REP_W(REP_W)) u_rep (
    .clk_i, .rst_ni, .ev_i(ev), .ug_i(ug), .rep_val_i(rep_val), .upd_o(upd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upd_q <= 1'b0;
    else         upd_q <= upd;
  end
  assign update_o = upd_q;

  // R8
  ug_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ug |=> update_o && cnt_o == '0);
endmodule

// File: tb/sim_rep_update_gen.sv
module sim_rep_update_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, cnt;
  logic        update, irq;
  int          total = 0, bad = 0, cyc = 0;

  rep_update_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .cnt_o(cnt), .update_o(update), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // {center, arr, rep, expected interval}
  localparam logic [44:0] VEC [6] = '{
    {1'b0, 16'd3, 8'd0,   20'd4},
    {1'b0, 16'd4, 8'd2,   20'd15},
    {1'b1, 16'd3, 8'd0,   20'd3},
    {1'b1, 16'd5, 8'd1,   20'd10},
    {1'b0, 16'd2, 8'd255, 20'd768},
    {1'b1, 16'd1, 8'd3,   20'd4}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_upd(output int t);
    int n = 0;
    do begin @(negedge clk); n++; end while (!update && n < 5000);
    t = cyc;
    if (n >= 5000) chk(1'b0, "timeout", n, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=expired exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int t1, t2, t3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk(cnt == 0, "R2 cnt", cnt, 0);
    chk(!update, "R2 update", update, 0);
    chk(!irq, "R2 irq", irq, 0);
    rd(2'd0, d); chk(d == 0, "R2 ctrl", d, 0);
    rd(2'd2, d); chk(d == 16'hFFFF, "R2 arr", d, 16'hFFFF);
    rd(2'd1, d); chk(d == 0, "R1 reset", d, 0);

    // R1 reserved bits
    wr(2'd1, 16'hABCD);
    rd(2'd1, d); chk(d == 16'h00CD, "R1 readback", d, 16'h00CD);

    // table of modes / reloads / repetitions: R3 R4 R5 R11
    foreach (VEC[i]) begin
      logic        c   = VEC[i][44];
      logic [15:0] a   = VEC[i][43:28];
      logic [7:0]  r   = VEC[i][27:20];
      int          exp = int'(VEC[i][19:0]);
      wr(2'd0, 16'h0);
      wr(2'd2, a);
      wr(2'd1, {8'h0, r});
      wr(2'd0, 16'h0009 | (c ? 16'h0002 : 16'h0));
      if (i == 0) begin
        chk(update == 1'b1, "R8 ug pulse", update, 1);
        chk(cnt == 0, "R8 ug cnt", cnt, 0);
      end
      wait_upd(t1); wait_upd(t2); wait_upd(t3);
      chk(t3 - t2 == exp, c ? "R4 interval" : "R3 interval", t3 - t2, exp);
      if (r == 0) chk(t3 - t2 == (c ? a : a + 1), "R5 every event", t3 - t2, c ? a : a + 1);
      @(negedge clk);
      chk(!update, "R11 width", update, 0);
    end

    // R6 repetition buffered
    wr(2'd0, 16'h0); wr(2'd2, 16'd3); wr(2'd1, 16'd1); wr(2'd0, 16'h0009);
    wait_upd(t1);
    wr(2'd1, 16'd3);
    wait_upd(t2); wait_upd(t3);
    chk(t2 - t1 == 8, "R6 old rep kept", t2 - t1, 8);
    chk(t3 - t2 == 16, "R6 new rep used", t3 - t2, 16);

    // R7 reload buffered
    wr(2'd0, 16'h0); wr(2'd2, 16'd3); wr(2'd1, 16'd0); wr(2'd0, 16'h0009);
    wait_upd(t1);
    wr(2'd2, 16'd5);
    wait_upd(t2); wait_upd(t3);
    chk(t2 - t1 == 4, "R7 old arr kept", t2 - t1, 4);
    chk(t3 - t2 == 6, "R7 new arr used", t3 - t2, 6);

    // R8 forced update mid-run resets counter
    repeat (2) @(negedge clk);
    wr(2'd0, 16'h0009);
    chk(update == 1'b1, "R8 mid-run pulse", update, 1);
    chk(cnt == 0, "R8 mid-run cnt", cnt, 0);

    // R10 flag stays clear without enable
    wait_upd(t1); wait_upd(t2);
    chk(!irq, "R10 no flag", irq, 0);

    // R9 flag set / hold / clear
    wr(2'd0, 16'h0005);
    wait_upd(t1);
    chk(irq == 1'b1, "R9 flag set", irq, 1);
    wr(2'd0, 16'h0);
    wr(2'd3, 16'h0001);
    chk(irq == 1'b1, "R9 write one holds", irq, 1);
    rd(2'd3, d); chk(d == 16'h1, "R9 status read", d, 1);
    wr(2'd3, 16'h0000);
    chk(!irq, "R9 write zero clears", irq, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule